// File: doc/BRIEF.md
# Instruction Size Attribute Resolver

This block sits in an instruction predecoder, after prefix parsing and before immediate collection. For each instruction it takes the precomputed mode summary fields, the REX.W bit, the two size-override prefix flags and the ModRM byte. It works out three byte sizes: the effective operand size, the address size and the stack width. It also gives the displacement length that a ModRM byte implies when the default operand size is 16 bits.

The summary supplies each size as a log2 value. There is a default and an alternate value for operands, a default and an alternate value for addresses, and one value for the stack. The resolver does not derive sizes from the processor mode. It only picks between the default and alternate values and turns the chosen log value into a byte count. REX.W takes priority over the operand override.

All results are computed combinationally. They are captured in one register stage on a valid strobe, and the strobe appears on the output one cycle later.

Top module: `insn_size_resolver`

## Requirements
- R1: After reset, `out_valid` is 0 and every data output (`op_bytes`, `addr_bytes`, `stack_bytes`, `disp_bytes`, `modrm32_rules`) is 0.
- R2: When `rex_w` is 1, `op_bytes` is 2**WIDE_LOG (8 by default), whatever the value of `op_ovr`.
- R3: When `rex_w` is 0, `op_bytes` is 2**`alt_op_log` if `op_ovr` is 1, and 2**`def_op_log` if `op_ovr` is 0.
- R4: `addr_bytes` is 2**`alt_addr_log` if `addr_ovr` is 1, and 2**`def_addr_log` if `addr_ovr` is 0.
- R5: `stack_bytes` is 2**`stack_log`. It holds exactly one set bit whenever a result has been captured.
- R6: When `def_op_log` equals 1, `disp_bytes` is 2 in two cases: the mod field (`modrm[7:6]`) is 2, or mod is 0 and the rm field (`modrm[2:0]`) is 6.
- R7: When `def_op_log` equals 1, `disp_bytes` is 1 for mod 1, and 0 for mod 3 or for mod 0 with any rm other than 6. `modrm32_rules` is 0 in all of these cases.
- R8: When `def_op_log` is not 1, `disp_bytes` is 0 and `modrm32_rules` is 1.
- R9: Outputs update only on a clock edge where `in_valid` is 1. `out_valid` equals `in_valid` from one cycle earlier. Input changes while `in_valid` is 0 have no effect on the data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the current inputs |
| def_op_log | input | LOG_W | Default operand log2 size |
| alt_op_log | input | LOG_W | Alternate operand log2 size |
| def_addr_log | input | LOG_W | Default address log2 size |
| alt_addr_log | input | LOG_W | Alternate address log2 size |
| stack_log | input | LOG_W | Stack log2 width |
| rex_w | input | 1 | Wide operand request, overrides `op_ovr` |
| op_ovr | input | 1 | Operand-size override prefix seen |
| addr_ovr | input | 1 | Address-size override prefix seen |
| modrm | input | 8 | ModRM byte (mod in [7:6], rm in [2:0]) |
| out_valid | output | 1 | Registered echo of `in_valid` |
| op_bytes | output | 2**LOG_W | Effective operand size in bytes |
| addr_bytes | output | 2**LOG_W | Effective address size in bytes |
| stack_bytes | output | 2**LOG_W | Stack width in bytes |
| disp_bytes | output | 2 | Displacement length under 16-bit ModRM rules |
| modrm32_rules | output | 1 | 1 when 32-bit ModRM rules apply and `disp_bytes` is not meaningful |

## Verification
The bench builds the block with LOG_W = 2 and WIDE_LOG = 3. With these values every log field has only four settings, so the full cross of all five fields and the three prefix bits is swept, which gives 8192 vectors. That sweep covers every priority case between REX.W and the operand override and every byte size from 1 to 8. A second sweep crosses each of the four default operand values with all 256 ModRM bytes, so every mod/rm pair is seen under both the 16-bit and the non-16-bit rules. Hold checks with the strobe low are placed between these sweeps.

// File: rtl/size_attr_pkg.sv
package size_attr_pkg;

  // Log2 size that marks a 16-bit default operand size.
  localparam int unsigned LOG_HALFWORD = 1;

  // ModRM field positions (fixed by the byte format).
  localparam int unsigned MOD_HI = 7;
  localparam int unsigned MOD_LO = 6;
  localparam int unsigned RM_HI  = 2;
  localparam int unsigned RM_LO  = 0;

  localparam int unsigned DISP_W = 2;

  typedef enum logic [DISP_W-1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } disp16_e;

  // Displacement length implied by a ModRM byte under 16-bit addressing.
  function automatic disp16_e disp16_of(input logic [7:0] mrm);
    logic [1:0] md;
    logic [2:0] rm;
    md = mrm[MOD_HI:MOD_LO];
    rm = mrm[RM_HI:RM_LO];
    case (md)
      2'd0:    return (rm == 3'd6) ? DISP_WORD : DISP_NONE;
      2'd1:    return DISP_BYTE;
      2'd2:    return DISP_WORD;
      default: return DISP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/size_sel.sv
module size_sel #(
  parameter int unsigned LOG_W     = 2,
  parameter int unsigned BYTES_W   = 4,
  parameter bit          HAS_FORCE = 1'b0,
  parameter int unsigned FORCE_LOG = 3
) (
  input  logic [LOG_W-1:0]   def_log,
  input  logic [LOG_W-1:0]   alt_log,
  input  logic               ovr,
  input  logic               force_wide,
  output logic [BYTES_W-1:0] bytes,
  output logic               use_alt,
  output logic               forced
);

  localparam logic [LOG_W-1:0] FORCE_SEL = LOG_W'(FORCE_LOG);

  function automatic logic [BYTES_W-1:0] pow2(input logic [LOG_W-1:0] l);
    return BYTES_W'(1) << l;
  endfunction

  logic [LOG_W-1:0] log_sel;

  always_comb begin
    forced  = HAS_FORCE & force_wide;
    use_alt = ovr & ~forced;
    if (forced)       log_sel = FORCE_SEL;
    else if (use_alt) log_sel = alt_log;
    else              log_sel = def_log;
    bytes = pow2(log_sel);
  end

endmodule

// File: rtl/disp_dec.sv
module disp_dec
  import size_attr_pkg::*;
#(
  parameter int unsigned LOG_W = 2
) (
  input  logic [LOG_W-1:0]  def_op_log,
  input  logic [7:0]        modrm,
  output logic [DISP_W-1:0] disp,
  output logic              rule32,
  output logic              mode16
);

  localparam logic [LOG_W-1:0] HALF = LOG_W'(LOG_HALFWORD);

  always_comb begin
    mode16 = (def_op_log == HALF);
    rule32 = ~mode16;
    disp   = mode16 ? disp16_of(modrm) : DISP_NONE;
  end

endmodule

// File: rtl/attr_pipe.sv
module attr_pipe #(
  parameter int unsigned W          = 8,
  parameter bit          RESET_DATA = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vout
);

  always_ff @(posedge clk) begin
    if (!rst_n) vout <= 1'b0;
    else        vout <= load;
  end

  generate
    if (RESET_DATA) begin : g_rst
      always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        if (load) q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/insn_size_resolver.sv
module insn_size_resolver
  import size_attr_pkg::*;
#(
  parameter int unsigned LOG_W    = 2,
  parameter int unsigned WIDE_LOG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LOG_W-1:0]    def_op_log,
  input  logic [LOG_W-1:0]    alt_op_log,
  input  logic [LOG_W-1:0]    def_addr_log,
  input  logic [LOG_W-1:0]    alt_addr_log,
  input  logic [LOG_W-1:0]    stack_log,
  input  logic                rex_w,
  input  logic                op_ovr,
  input  logic                addr_ovr,
  input  logic [7:0]          modrm,
  output logic                out_valid,
  output logic [(1<<LOG_W)-1:0] op_bytes,
  output logic [(1<<LOG_W)-1:0] addr_bytes,
  output logic [(1<<LOG_W)-1:0] stack_bytes,
  output logic [1:0]          disp_bytes,
  output logic                modrm32_rules
);

  localparam int unsigned BYTES_W = 1 << LOG_W;
  localparam int unsigned PACK_W  = 3*BYTES_W + DISP_W + 1;

  // Named internal events, visible to the checker.
  logic               load_en;
  logic               op_use_alt, op_forced;
  logic               addr_use_alt, addr_forced;
  logic               stk_use_alt, stk_forced;
  logic               mode16;
  logic [BYTES_W-1:0] op_nx, addr_nx, stk_nx;
  logic [DISP_W-1:0]  disp_nx;
  logic               rule32_nx;
  logic [PACK_W-1:0]  pack_d, pack_q;

  assign load_en = in_valid;

  size_sel #(.LOG_W(LOG_W), .BYTES_W(BYTES_W), .HAS_FORCE(1'b1), .FORCE_LOG(WIDE_LOG)) u_op (
    .def_log(def_op_log), .alt_log(alt_op_log), .ovr(op_ovr), .force_wide(rex_w),
    .bytes(op_nx), .use_alt(op_use_alt), .forced(op_forced));

  size_sel #(.LOG_W(LOG_W), .BYTES_W(BYTES_W), .HAS_FORCE(1'b0), .FORCE_LOG(WIDE_LOG)) u_addr (
    .def_log(def_addr_log), .alt_log(alt_addr_log), .ovr(addr_ovr), .force_wide(1'b0),
    .bytes(addr_nx), .use_alt(addr_use_alt), .forced(addr_forced));

  size_sel #(.LOG_W(LOG_W), .BYTES_W(BYTES_W), .HAS_FORCE(1'b0), .FORCE_LOG(WIDE_LOG)) u_stk (
    .def_log(stack_log), .alt_log(stack_log), .ovr(1'b0), .force_wide(1'b0),
    .bytes(stk_nx), .use_alt(stk_use_alt), .forced(stk_forced));

  disp_dec #(.LOG_W(LOG_W)) u_disp (
    .def_op_log(def_op_log), .modrm(modrm),
    .disp(disp_nx), .rule32(rule32_nx), .mode16(mode16));

  assign pack_d = {op_nx, addr_nx, stk_nx, disp_nx, rule32_nx};

  attr_pipe #(.W(PACK_W), .RESET_DATA(1'b1)) u_pipe (
    .clk(clk), .rst_n(rst_n), .load(load_en), .d(pack_d), .q(pack_q), .vout(out_valid));

  assign {op_bytes, addr_bytes, stack_bytes, disp_bytes, modrm32_rules} = pack_q;

endmodule

// File: rtl/insn_size_resolver_chk.sv
module insn_size_resolver_chk #(
  parameter int unsigned LOG_W    = 2,
  parameter int unsigned WIDE_LOG = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  rex_w,
  input logic                  op_ovr,
  input logic [LOG_W-1:0]      def_op_log,
  input logic [LOG_W-1:0]      alt_op_log,
  input logic [7:0]            modrm,
  input logic                  op_forced,
  input logic                  mode16,
  input logic                  out_valid,
  input logic [(1<<LOG_W)-1:0] op_bytes,
  input logic [(1<<LOG_W)-1:0] addr_bytes,
  input logic [(1<<LOG_W)-1:0] stack_bytes,
  input logic [1:0]            disp_bytes,
  input logic                  modrm32_rules
);

  localparam int unsigned BYTES_W = 1 << LOG_W;
  localparam logic [BYTES_W-1:0] WIDE_BYTES = BYTES_W'(1) << WIDE_LOG;

  p_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(op_bytes) && $stable(addr_bytes) && $stable(stack_bytes)
                   && $stable(disp_bytes) && $stable(modrm32_rules)));

  p_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_forced) |=> (op_bytes == WIDE_BYTES));

  p_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rex_w && op_ovr) |=> (op_bytes == (BYTES_W'(1) << $past(alt_op_log))));

  p_pow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(stack_bytes) == 1));

  p_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode16 && modrm[7:6] == 2'd2) |=> (disp_bytes == 2'd2));

  p_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && def_op_log == LOG_W'(1) && modrm[7:6] == 2'd3)
      |=> (disp_bytes == 2'd0 && !modrm32_rules));

  p_flat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && modrm32_rules) |-> (disp_bytes == 2'd0));

endmodule

bind insn_size_resolver insn_size_resolver_chk #(.LOG_W(LOG_W), .WIDE_LOG(WIDE_LOG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rex_w(rex_w), .op_ovr(op_ovr),
  .def_op_log(def_op_log), .alt_op_log(alt_op_log), .modrm(modrm),
  .op_forced(op_forced), .mode16(mode16), .out_valid(out_valid),
  .op_bytes(op_bytes), .addr_bytes(addr_bytes), .stack_bytes(stack_bytes),
  .disp_bytes(disp_bytes), .modrm32_rules(modrm32_rules));

// File: tb/sim_insn_size_resolver.sv
`timescale 1ns/1ps
module sim_insn_size_resolver;

  localparam int LOG_W = 2;
  localparam int WIDE_LOG = 3;
  localparam int BW = 1 << LOG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [LOG_W-1:0] def_op_log = '0, alt_op_log = '0, def_addr_log = '0, alt_addr_log = '0, stack_log = '0;
  logic rex_w = 1'b0, op_ovr = 1'b0, addr_ovr = 1'b0;
  logic [7:0] modrm = '0;
  logic out_valid;
  logic [BW-1:0] op_bytes, addr_bytes, stack_bytes;
  logic [1:0] disp_bytes;
  logic modrm32_rules;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  insn_size_resolver #(.LOG_W(LOG_W), .WIDE_LOG(WIDE_LOG)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .def_op_log(def_op_log), .alt_op_log(alt_op_log),
    .def_addr_log(def_addr_log), .alt_addr_log(alt_addr_log), .stack_log(stack_log),
    .rex_w(rex_w), .op_ovr(op_ovr), .addr_ovr(addr_ovr), .modrm(modrm),
    .out_valid(out_valid), .op_bytes(op_bytes), .addr_bytes(addr_bytes),
    .stack_bytes(stack_bytes), .disp_bytes(disp_bytes), .modrm32_rules(modrm32_rules));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one vector with the strobe high, then sample one cycle later.
  task automatic apply(input int dop, input int aop, input int dad, input int aad,
                       input int stk, input bit w, input bit oo, input bit ao, input int mrm);
    @(negedge clk);
    def_op_log = LOG_W'(dop); alt_op_log = LOG_W'(aop);
    def_addr_log = LOG_W'(dad); alt_addr_log = LOG_W'(aad);
    stack_log = LOG_W'(stk); rex_w = w; op_ovr = oo; addr_ovr = ao;
    modrm = 8'(mrm); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int exp_disp(input int dop, input int mrm);
    int md;
    int rm;
    md = mrm / 64;
    rm = mrm % 8;
    if (dop != 1) return 0;
    if (md == 2) return 2;
    if (md == 1) return 1;
    if (md == 0 && rm == 6) return 2;
    return 0;
  endfunction

  task automatic hold_check(input string tag);
    int o, a, s, d, f;
    o = int'(op_bytes); a = int'(addr_bytes); s = int'(stack_bytes);
    d = int'(disp_bytes); f = int'(modrm32_rules);
    @(negedge clk);
    def_op_log = ~def_op_log; alt_op_log = ~alt_op_log; def_addr_log = ~def_addr_log;
    alt_addr_log = ~alt_addr_log; stack_log = ~stack_log; rex_w = ~rex_w;
    op_ovr = ~op_ovr; addr_ovr = ~addr_ovr; modrm = ~modrm; in_valid = 1'b0;
    @(negedge clk);
    chk({tag, " out_valid low"}, int'(out_valid), 0);
    chk({tag, " op held"}, int'(op_bytes), o);
    chk({tag, " addr held"}, int'(addr_bytes), a);
    chk({tag, " stack held"}, int'(stack_bytes), s);
    chk({tag, " disp held"}, int'(disp_bytes), d);
    chk({tag, " flag held"}, int'(modrm32_rules), f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 op_bytes", int'(op_bytes), 0);
    chk("R1 addr_bytes", int'(addr_bytes), 0);
    chk("R1 stack_bytes", int'(stack_bytes), 0);
    chk("R1 disp_bytes", int'(disp_bytes), 0);
    chk("R1 modrm32_rules", int'(modrm32_rules), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep A: all size fields crossed with all prefix bits.
    for (int dop = 0; dop < 4; dop++)
      for (int aop = 0; aop < 4; aop++)
        for (int dad = 0; dad < 4; dad++)
          for (int aad = 0; aad < 4; aad++)
            for (int stk = 0; stk < 4; stk++)
              for (int pf = 0; pf < 8; pf++) begin
                bit w, oo, ao;
                int eop;
                w = pf[0]; oo = pf[1]; ao = pf[2];
                apply(dop, aop, dad, aad, stk, w, oo, ao, 8'h80);
                chk("R9 out_valid echo", int'(out_valid), 1);
                if (w) begin
                  eop = 2 ** WIDE_LOG;
                  chk("R2 op_bytes wide", int'(op_bytes), eop);
                end else begin
                  eop = oo ? (2 ** aop) : (2 ** dop);
                  chk("R3 op_bytes", int'(op_bytes), eop);
                end
                chk("R4 addr_bytes", int'(addr_bytes), ao ? (2 ** aad) : (2 ** dad));
                chk("R5 stack_bytes", int'(stack_bytes), 2 ** stk);
              end

    hold_check("R9 after sweep A");

    // Sweep B: default operand size crossed with every ModRM byte.
    for (int dop = 0; dop < 4; dop++)
      for (int mrm = 0; mrm < 256; mrm++) begin
        int ed;
        apply(dop, 2, 1, 2, 1, 1'b0, 1'b0, 1'b0, mrm);
        ed = exp_disp(dop, mrm);
        if (dop != 1) begin
          chk("R8 disp_bytes zero", int'(disp_bytes), 0);
          chk("R8 modrm32_rules set", int'(modrm32_rules), 1);
        end else begin
          if (ed == 2) chk("R6 disp_bytes word", int'(disp_bytes), ed);
          else         chk("R7 disp_bytes", int'(disp_bytes), ed);
          chk("R7 modrm32_rules clear", int'(modrm32_rules), 0);
        end
      end

    hold_check("R9 after sweep B");

    // R2 with override present and a mode16 ModRM: both fields at once.
    apply(1, 0, 1, 1, 2, 1'b1, 1'b1, 1'b0, 8'h06);
    chk("R2 wide beats override", int'(op_bytes), 2 ** WIDE_LOG);
    chk("R6 mod0 rm6", int'(disp_bytes), 2);
    hold_check("R9 final");

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule